// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a processor core through three low-power modes: a light idle mode, a standby mode and a deep halt mode. Software writes a 2-bit mode field and a qualification count into a control register, and a 32-bit wake-select mask into a second register. A one-cycle sleep request, issued when the core executes its sleep instruction, moves the block from active operation into the selected mode.

In each mode the block drives enables for the oscillator, the PLL, the CPU clock input and the system clock output. It also watches the exit sources allowed in that mode: external reset, the watchdog interrupt, a pending enabled interrupt, a debugger wake request, and the 32 GPIO lines filtered by the mask. In standby, a GPIO wake must hold steady for a programmable number of oscillator clocks. In halt, a selected GPIO line wakes the block at once.

When the block leaves standby or halt, it turns the clocks back on in a fixed order: oscillator, then CPU clock, then system clock output, one cycle apart. External reset is asynchronous and overrides everything else.

Top module: `lpm_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, the state is active (lpm_state_o = 0), all four enables are 1, and the mode, qualification count and mask read back as 0.
- R2: When sleep_req_i is high in the active state, the block moves on the next edge to the state set by the mode field (ctrl register bits [1:0]). A value of 00 selects idle (state 1, all enables 1). A value of 01 selects standby (state 2, oscillator and PLL on, CPU and system clocks off). A value of 1x selects halt (state 3, all enables 0).
- R3: Idle returns to active on the next edge when wdog_irq_i or irq_pend_i is high. dbg_wake_i and the GPIO lines have no effect in idle.
- R4: Standby goes to the restore sequence on the next edge when wdog_irq_i or dbg_wake_i is high. irq_pend_i has no effect in standby.
- R5: In standby, a selected GPIO line that is high wakes the block only on the (N+1)-th consecutive clock edge at which it is sampled high. N is the qualification count in ctrl register bits [15:8].
- R6: If the selected GPIO wake drops before the count completes, qualification starts again from zero.
- R7: Halt goes to the restore sequence on the next edge when a selected GPIO line, dbg_wake_i or wdog_irq_i is high. The GPIO wake needs no qualification. irq_pend_i has no effect in halt.
- R8: A GPIO line whose bit in the mask register is 0 never wakes the block.
- R9: The restore sequence is state 4 (oscillator and PLL on), then state 5 (CPU clock also on), then active (system clock also on), one edge apart.
- R10: Pulling rst_ni low in any state immediately forces the active state with all enables on, and returns the registers to their default values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | External reset, asynchronous, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 ctrl (mode [1:0], qualification count [15:8]), 1 wake mask |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data of the selected register |
| sleep_req_i | input | 1 | Sleep instruction executed |
| wdog_irq_i | input | 1 | Watchdog interrupt |
| irq_pend_i | input | 1 | Enabled interrupt pending |
| dbg_wake_i | input | 1 | Debugger wake request |
| gpio_i | input | 32 | GPIO port wake inputs |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL and crystal enable |
| cpu_clk_en_o | output | 1 | CPU clock input enable |
| sysclk_en_o | output | 1 | System clock output enable |
| lpm_state_o | output | 3 | Controller state code |

## Verification
The hardest case to reach is a standby GPIO wake that drops out one edge before qualification completes and then comes back. Only the restarted count shows whether the counter was cleared. The bench sets a count of 3 and holds the selected line high for exactly three edges. It then drops the line for one edge and raises it again. It checks that the block is still in standby after three more edges and that it wakes on the fourth. A vector table covers the acceptance and rejection of every exit source in each mode, including mode 11 as halt.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_IDLE    = 3'd1,
    ST_STBY    = 3'd2,
    ST_HALT    = 3'd3,
    ST_RST_OSC = 3'd4,
    ST_RST_CPU = 3'd5
  } lpm_state_e;

  localparam int unsigned QUAL_LSB = 8;
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
  parameter int unsigned GPIO_W = 32,
  parameter int unsigned QUAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        mode_o,
  output logic [QUAL_W-1:0] qual_o,
  output logic [GPIO_W-1:0] mask_o
);
  import lpm_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      qual_o <= '0;
      mask_o <= '0;
    end else if (we_i) begin
      if (sel_i) begin
        mask_o <= wdata_i[GPIO_W-1:0];
      end else begin
        mode_o <= wdata_i[1:0];
        qual_o <= wdata_i[QUAL_LSB +: QUAL_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      rdata_o[GPIO_W-1:0] = mask_o;
    end else begin
      rdata_o[1:0]                 = mode_o;
      rdata_o[QUAL_LSB +: QUAL_W]  = qual_o;
    end
  end
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int unsigned GPIO_W = 32,
  parameter int unsigned QUAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic [GPIO_W-1:0] mask_i,
  input  logic [QUAL_W-1:0] qual_i,
  output logic              hit_o,
  output logic              done_o
);
  logic [QUAL_W-1:0] cnt_q;

  assign hit_o = |(gpio_i & mask_i);

  // counts consecutive hit edges before the current one; saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!arm_i || !hit_o)     cnt_q <= '0;
    else if (cnt_q != '1)          cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = arm_i && hit_o && (cnt_q >= qual_i);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                sleep_req_i,
  input  logic                wdog_irq_i,
  input  logic                irq_pend_i,
  input  logic                dbg_wake_i,
  input  logic                gpio_hit_i,
  input  logic                qual_done_i,
  output lpm_pkg::lpm_state_e state_o,
  output logic                osc_en_o,
  output logic                cpu_en_o,
  output logic                sys_en_o
);
  import lpm_pkg::*;

  lpm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: if (sleep_req_i) begin
        if (mode_i[1])      state_d = ST_HALT;
        else if (mode_i[0]) state_d = ST_STBY;
        else                state_d = ST_IDLE;
      end
      ST_IDLE:    if (wdog_irq_i || irq_pend_i)                state_d = ST_ACTIVE;
      ST_STBY:    if (wdog_irq_i || dbg_wake_i || qual_done_i) state_d = ST_RST_OSC;
      ST_HALT:    if (wdog_irq_i || dbg_wake_i || gpio_hit_i)  state_d = ST_RST_OSC;
      ST_RST_OSC: state_d = ST_RST_CPU;
      ST_RST_CPU: state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  always_comb begin
    {osc_en_o, cpu_en_o, sys_en_o} = 3'b111;
    case (state_q)
      ST_STBY:    {osc_en_o, cpu_en_o, sys_en_o} = 3'b100;
      ST_HALT:    {osc_en_o, cpu_en_o, sys_en_o} = 3'b000;
      ST_RST_OSC: {osc_en_o, cpu_en_o, sys_en_o} = 3'b100;
      ST_RST_CPU: {osc_en_o, cpu_en_o, sys_en_o} = 3'b110;
      default:    {osc_en_o, cpu_en_o, sys_en_o} = 3'b111;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int unsigned GPIO_W = 32,
  parameter int unsigned QUAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              sleep_req_i,
  input  logic              wdog_irq_i,
  input  logic              irq_pend_i,
  input  logic              dbg_wake_i,
  input  logic [GPIO_W-1:0] gpio_i,
  output logic              osc_en_o,
  output logic              pll_en_o,
  output logic              cpu_clk_en_o,
  output logic              sysclk_en_o,
  output logic [2:0]        lpm_state_o
);
  import lpm_pkg::*;

  logic [1:0]        mode_q;
  logic [QUAL_W-1:0] qual_q;
  logic [GPIO_W-1:0] mask_q;
  logic              gpio_hit, qual_done;
  lpm_state_e        state;

  lpm_regs #(.GPIO_W(GPIO_W), .QUAL_W(QUAL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .mode_o  (mode_q),
    .qual_o  (qual_q),
    .mask_o  (mask_q)
  );

  lpm_wake_qual #(.GPIO_W(GPIO_W), .QUAL_W(QUAL_W)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (state == ST_STBY),
    .gpio_i (gpio_i),
    .mask_i (mask_q),
    .qual_i (qual_q),
    .hit_o  (gpio_hit),
    .done_o (qual_done)
  );

  // halt: no qualification clock, take the raw masked hit
  lpm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .sleep_req_i (sleep_req_i),
    .wdog_irq_i  (wdog_irq_i),
    .irq_pend_i  (irq_pend_i),
    .dbg_wake_i  (dbg_wake_i),
    .gpio_hit_i  (gpio_hit),
    .qual_done_i (qual_done),
    .state_o     (state),
    .osc_en_o    (osc_en_o),
    .cpu_en_o    (cpu_clk_en_o),
    .sys_en_o    (sysclk_en_o)
  );

  assign pll_en_o    = osc_en_o;
  assign lpm_state_o = state;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int unsigned GPIO_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        state_i,
  input logic              osc_i,
  input logic              pll_i,
  input logic              cpu_i,
  input logic              sys_i,
  input logic              wdog_i,
  input logic              irq_i,
  input logic              dbg_i,
  input logic [GPIO_W-1:0] gpio_i,
  input logic [GPIO_W-1:0] mask_i
);
  p_idle_clocks_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd1 |-> osc_i && pll_i && cpu_i && sys_i);

  p_stby_gating_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd2 |-> osc_i && pll_i && !cpu_i && !sys_i);

  p_halt_gating_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd3 |-> !osc_i && !pll_i && !cpu_i && !sys_i);

  p_idle_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd1 && !wdog_i && !irq_i) |=> state_i == 3'd1);

  p_halt_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd3 && !wdog_i && !dbg_i && ((gpio_i & mask_i) == '0)) |=> state_i == 3'd3);

  p_cpu_after_osc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_i) |-> osc_i && !sys_i && $past(osc_i));

  p_sys_after_cpu_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_i) |-> $past(cpu_i));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.GPIO_W(GPIO_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .state_i (lpm_state_o),
  .osc_i   (osc_en_o),
  .pll_i   (pll_en_o),
  .cpu_i   (cpu_clk_en_o),
  .sys_i   (sysclk_en_o),
  .wdog_i  (wdog_irq_i),
  .irq_i   (irq_pend_i),
  .dbg_i   (dbg_wake_i),
  .gpio_i  (gpio_i),
  .mask_i  (mask_q)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        sleep_req = 1'b0, wdog = 1'b0, irq = 1'b0, dbg = 1'b0;
  logic [31:0] gpio = '0;
  logic        osc_en, pll_en, cpu_en, sys_en;
  logic [2:0]  state;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  lpm_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .sleep_req_i(sleep_req),
    .wdog_irq_i(wdog), .irq_pend_i(irq), .dbg_wake_i(dbg), .gpio_i(gpio),
    .osc_en_o(osc_en), .pll_en_o(pll_en), .cpu_clk_en_o(cpu_en),
    .sysclk_en_o(sys_en), .lpm_state_o(state)
  );

  // vector: [8:7] mode, [6] wdog, [5] irq, [4] dbg, [3] gpio bit 0, [2:0] expected state
  localparam logic [8:0] VEC [12] = '{
    {2'b00, 4'b1000, 3'd0}, {2'b00, 4'b0100, 3'd0},
    {2'b00, 4'b0010, 3'd1}, {2'b00, 4'b0001, 3'd1},
    {2'b01, 4'b1000, 3'd4}, {2'b01, 4'b0100, 3'd2},
    {2'b01, 4'b0010, 3'd4}, {2'b01, 4'b0001, 3'd4},
    {2'b10, 4'b0001, 3'd4}, {2'b10, 4'b0010, 3'd4},
    {2'b10, 4'b0100, 3'd3}, {2'b11, 4'b1000, 3'd4}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0; cfg_sel = 1'b0;
  endtask

  task automatic enter(logic [1:0] mode);
    wr(1'b0, {24'h0, 6'h0, mode});
    sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
  endtask

  function automatic string mode_tag(logic [1:0] m);
    return m[1] ? "R7" : (m[0] ? "R4" : "R3");
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(1);
    chk("R1 state in reset", {29'b0, state}, 0);
    chk("R1 enables in reset", {28'b0, osc_en, pll_en, cpu_en, sys_en}, 32'hF);
    rst_ni = 1'b1;
    tick(1);
    chk("R1 ctrl default", cfg_rdata, 0);
    cfg_sel = 1'b1; #1;
    chk("R1 mask default", cfg_rdata, 0);
    cfg_sel = 1'b0;

    // table walk: R2 entry, R3/R4/R7 exit sources
    foreach (VEC[i]) begin
      logic [1:0] m;
      m = VEC[i][8:7];
      do_reset();
      wr(1'b1, 32'hFFFF_FFFF);
      enter(m);
      chk($sformatf("R2 entry vec %0d", i), {29'b0, state},
          m[1] ? 3 : (m[0] ? 2 : 1));
      {wdog, irq, dbg} = VEC[i][6:4];
      gpio[0] = VEC[i][3];
      tick(1);
      chk($sformatf("%s exit vec %0d", mode_tag(m), i), {29'b0, state}, {29'b0, VEC[i][2:0]});
      {wdog, irq, dbg} = 3'b000;
      gpio = '0;
    end

    // R2 enables in standby and halt
    do_reset();
    enter(2'b01);
    chk("R2 standby enables", {28'b0, osc_en, pll_en, cpu_en, sys_en}, 32'hC);
    do_reset();
    enter(2'b10);
    chk("R2 halt enables", {28'b0, osc_en, pll_en, cpu_en, sys_en}, 32'h0);

    // R9 restore order from halt
    dbg = 1'b1;
    tick(1);
    dbg = 1'b0;
    chk("R9 restore step 1", {25'b0, state, osc_en, pll_en, cpu_en, sys_en}, {25'b0, 3'd4, 4'b1100});
    tick(1);
    chk("R9 restore step 2", {25'b0, state, osc_en, pll_en, cpu_en, sys_en}, {25'b0, 3'd5, 4'b1110});
    tick(1);
    chk("R9 restore done", {25'b0, state, osc_en, pll_en, cpu_en, sys_en}, {25'b0, 3'd0, 4'b1111});

    // R5 and R6: qualification count 3 on line 5
    do_reset();
    wr(1'b1, 32'h0000_0020);
    wr(1'b0, 32'h0000_0301);
    chk("R5 ctrl readback", cfg_rdata, 32'h0000_0301);
    sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
    gpio[5] = 1'b1;
    tick(3);
    chk("R6 no wake after 3 edges", {29'b0, state}, 2);
    gpio[5] = 1'b0;
    tick(1);
    gpio[5] = 1'b1;
    tick(3);
    chk("R6 counter restarted", {29'b0, state}, 2);
    tick(1);
    chk("R5 wake on 4th edge", {29'b0, state}, 4);
    gpio = '0;

    // R8 unselected line ignored in halt and standby
    do_reset();
    wr(1'b1, 32'h0000_0020);
    enter(2'b10);
    gpio[4] = 1'b1;
    tick(2);
    chk("R8 masked line in halt", {29'b0, state}, 3);
    gpio[4] = 1'b0;
    gpio[5] = 1'b1;
    tick(1);
    chk("R7 selected line in halt", {29'b0, state}, 4);
    gpio = '0;
    do_reset();
    wr(1'b1, 32'h0000_0020);
    enter(2'b01);
    gpio = 32'hFFFF_FFDF;
    tick(3);
    chk("R8 masked lines in standby", {29'b0, state}, 2);
    gpio = '0;

    // R10 async reset from halt
    do_reset();
    wr(1'b1, 32'h0000_0001);
    enter(2'b10);
    #2 rst_ni = 1'b0;
    #1;
    chk("R10 async state", {25'b0, state, osc_en, pll_en, cpu_en, sys_en}, {25'b0, 3'd0, 4'b1111});
    chk("R10 ctrl cleared", cfg_rdata, 0);
    cfg_sel = 1'b1; #1;
    chk("R10 mask cleared", cfg_rdata, 0);
    cfg_sel = 1'b0;
    tick(1);
    rst_ni = 1'b1;
    tick(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule